// File: doc/BRIEF.md
# Segmented DAC Predistortion Code Remapper

This block sits between a user data path and a compact three-segment DAC whose upper segments are deliberately poorly matched. It takes a 14-bit input code, splits it into a 5-bit upper field, a 4-bit middle field and a 5-bit lower field, and returns corrected switch codes for the three segments. It also returns two enables for redundant current sources. The enables close output gaps where a mismatched segment jumps upward by more than one step. The result is a DAC output that follows a straight line, although the analog elements do not.

The correction is hierarchical. A per-code error for the upper segment is removed from the combined middle-and-lower value, borrowing from the upper field when the value goes negative. The first redundant source absorbs any excess above the middle segment's range. The value is then rounded into a middle code. A per-code error for the middle segment is removed from the remaining residue, again borrowing when needed. The second redundant source absorbs residue above a loaded saturation threshold.

The error tables, the two measured redundant weights and the threshold are loaded through a simple write port. Codes stream in with a valid strobe, one per cycle, and emerge a fixed number of cycles later. A sticky flag records any code that could not be corrected and had to be clamped.

Top module: `dac_code_remapper`

## Requirements
- R1: After reset, outValid, errFlag and all output codes are 0. Both error tables reset to 0, both redundant weights reset to 0 and the threshold resets to 31.
- R2: A code accepted with inValid in cycle t appears with outValid exactly 3 clock edges later. A new code may be accepted on every cycle.
- R3: The working value is low = mid*32 + lower − upperErr[upper]. If low < 0 and upper > 0, the upper code drops by one and 512 is added to low. If low < 0 and upper = 0, low becomes 0, the upper code stays 0 and the code counts as clamped.
- R4: If low exceeds 480 after step R3, redA is set and the first redundant weight is subtracted from low. Otherwise redA is 0.
- R5: The middle code is floor((low + 16) / 32), which rounds to nearest with halves going up. A result above 15 becomes 15 and a result below 0 becomes 0; either case counts as clamped.
- R6: The residue is res = low − mid*32 − midErr[mid], using the rounded middle code as the index. If res < 0 and mid > 0, mid drops by one and 32 is added to res. If res < 0 and mid = 0, the code counts as clamped.
- R7: If the residue exceeds the loaded threshold (compared as signed against the unsigned threshold), redB is set and the second redundant weight is subtracted. Otherwise redB is 0.
- R8: The final lower code is limited to 0..31; any limiting counts as clamped. errFlag rises with outValid of the first clamped code and stays high until reset.
- R9: Each write with cfgWe=1 takes one cycle. cfgSel=0 writes upperErr[cfgAddr] from cfgData[7:0]. cfgSel=1 writes midErr[cfgAddr[3:0]] from cfgData[7:0]. Both are two's complement. cfgSel=2 writes the full 10 bits of cfgData: with cfgAddr=0 the first weight (signed), with cfgAddr=1 the second weight (signed), and with cfgAddr=2 the threshold (unsigned).
- R10: While no result is delivered, the output codes and enables hold their last values and outValid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input code strobe |
| codeIn | input | 14 | User code |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 2 | Configuration target: upper table, middle table, misc |
| cfgAddr | input | 5 | Table index or misc register index |
| cfgData | input | 10 | Write data |
| outValid | output | 1 | Result strobe |
| msbCode | output | 5 | Corrected upper segment code |
| isbCode | output | 4 | Corrected middle segment code |
| lsbCode | output | 5 | Corrected lower segment code |
| redA | output | 1 | First redundant source enable |
| redB | output | 1 | Second redundant source enable |
| errFlag | output | 1 | Sticky clamp indicator |

## Verification
Every one of the 16384 input codes is swept back to back under two loaded configurations: one with zero errors, and one with signed errors spread over the whole table range plus nonzero weights and a lowered threshold. This forces upper borrows, first-source activation near the top of each upper step, rounding across half-steps, and middle borrows. A design that indexed the middle table after the borrow, rounded half-down, or compared against 479 instead of 480 would shift one segment code or one enable on a scattered subset of codes, and the comparison would flag it. A forced underflow at code 0 must clamp and raise the sticky flag, where a design that wrapped the upper code would emit 31. Checks during idle cycles catch outputs that drift when no result is delivered.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stageStrobe_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         clipNow,
  output stageStrobe_t strb,
  output logic         outValid,
  output logic         errFlag
);
  logic v1, v2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      outValid <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      outValid <= v2;
      errFlag <= errFlag | (v2 & clipNow);
    end
  end

  always_comb begin
    strb.ld1 = inValid;
    strb.ld2 = v1;
    strb.ld3 = v2;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##3 outValid);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);
endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int MSB_W = 5,
  parameter int ISB_W = 4,
  parameter int LSB_W = 5,
  parameter int ERR_W = 8,
  parameter int CFG_W = 10,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stageStrobe_t            strb,
  input  logic [MSB_W+ISB_W+LSB_W-1:0] codeIn,
  input  logic                    cfgWe,
  input  logic [1:0]              cfgSel,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [CFG_W-1:0]        cfgData,
  output logic [MSB_W-1:0]        msbCode,
  output logic [ISB_W-1:0]        isbCode,
  output logic [LSB_W-1:0]        lsbCode,
  output logic                    redA,
  output logic                    redB,
  output logic                    clipNow
);
  localparam int CODE_W   = MSB_W + ISB_W + LSB_W;
  localparam int LOW_W    = ISB_W + LSB_W;
  localparam int MSB_N    = 1 << MSB_W;
  localparam int ISB_N    = 1 << ISB_W;
  localparam int LSB_SPAN = 1 << LSB_W;
  localparam int LOW_SPAN = 1 << LOW_W;
  localparam int ISB_TOP  = (ISB_N - 1) * LSB_SPAN;
  localparam int HALF     = LSB_SPAN / 2;
  localparam int LSB_MAX  = LSB_SPAN - 1;
  localparam int ACC_W    = LOW_W + 3;
  localparam int THR_RST  = LSB_MAX;

  logic signed [ERR_W-1:0] msbErr [MSB_N];
  logic signed [ERR_W-1:0] isbErr [ISB_N];
  logic signed [CFG_W-1:0] wr1, wr2;
  logic [CFG_W-1:0]        thr;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MSB_N; i++) msbErr[i] <= '0;
      for (int i = 0; i < ISB_N; i++) isbErr[i] <= '0;
      wr1 <= '0;
      wr2 <= '0;
      thr <= CFG_W'(THR_RST);
    end else if (cfgWe) begin
      case (cfgSel)
        2'd0: msbErr[cfgAddr[MSB_W-1:0]] <= $signed(cfgData[ERR_W-1:0]);
        2'd1: isbErr[cfgAddr[ISB_W-1:0]] <= $signed(cfgData[ERR_W-1:0]);
        2'd2: begin
          if (cfgAddr == ADDR_W'(0)) wr1 <= $signed(cfgData);
          else if (cfgAddr == ADDR_W'(1)) wr2 <= $signed(cfgData);
          else if (cfgAddr == ADDR_W'(2)) thr <= cfgData;
        end
        default: ;
      endcase
    end
  end

  // stage 1: upper error removal, borrow, first redundant source
  logic signed [ACC_W-1:0] low0;
  logic [MSB_W-1:0]        cm1;
  logic                    sw1n, clip1n;
  logic signed [ACC_W-1:0] s1Low;
  logic [MSB_W-1:0]        s1Cm;
  logic                    s1Sw1, s1Clip;

  always_comb begin
    cm1 = codeIn[CODE_W-1:LOW_W];
    low0 = $signed(ACC_W'(codeIn[LOW_W-1:0])) - ACC_W'(msbErr[cm1]);
    clip1n = 1'b0;
    sw1n = 1'b0;
    if (low0 < 0) begin
      if (cm1 == '0) begin
        low0 = '0;
        clip1n = 1'b1;
      end else begin
        cm1 = cm1 - 1'b1;
        low0 = low0 + ACC_W'(LOW_SPAN);
      end
    end
    if (low0 > ACC_W'(ISB_TOP)) begin
      sw1n = 1'b1;
      low0 = low0 - ACC_W'(wr1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Low <= '0; s1Cm <= '0; s1Sw1 <= 1'b0; s1Clip <= 1'b0;
    end else if (strb.ld1) begin
      s1Low <= low0; s1Cm <= cm1; s1Sw1 <= sw1n; s1Clip <= clip1n;
    end
  end

  // stage 2: round into the middle segment
  logic signed [ACC_W-1:0] rnd, res2;
  logic [ISB_W-1:0]        ci2;
  logic                    clip2n;
  logic signed [ACC_W-1:0] s2Res;
  logic [ISB_W-1:0]        s2Ci;
  logic [MSB_W-1:0]        s2Cm;
  logic                    s2Sw1, s2Clip;

  always_comb begin
    rnd = (s1Low + ACC_W'(HALF)) >>> LSB_W;
    clip2n = s1Clip;
    if (rnd < 0) begin
      ci2 = '0;
      clip2n = 1'b1;
    end else if (rnd > ACC_W'(ISB_N - 1)) begin
      ci2 = '1;
      clip2n = 1'b1;
    end else begin
      ci2 = rnd[ISB_W-1:0];
    end
    res2 = s1Low - $signed(ACC_W'({ci2, LSB_W'(0)}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2Res <= '0; s2Ci <= '0; s2Cm <= '0; s2Sw1 <= 1'b0; s2Clip <= 1'b0;
    end else if (strb.ld2) begin
      s2Res <= res2; s2Ci <= ci2; s2Cm <= s1Cm; s2Sw1 <= s1Sw1; s2Clip <= clip2n;
    end
  end

  // stage 3: middle error removal, borrow, second redundant source, limit
  logic signed [ACC_W-1:0] cl3;
  logic [ISB_W-1:0]        ci3;
  logic [LSB_W-1:0]        clOut3;
  logic                    sw2n;

  always_comb begin
    cl3 = s2Res - ACC_W'(isbErr[s2Ci]);
    ci3 = s2Ci;
    clipNow = s2Clip;
    sw2n = 1'b0;
    if (cl3 < 0) begin
      if (ci3 == '0) begin
        clipNow = 1'b1;
      end else begin
        ci3 = ci3 - 1'b1;
        cl3 = cl3 + ACC_W'(LSB_SPAN);
      end
    end
    if (cl3 > $signed(ACC_W'(thr))) begin
      sw2n = 1'b1;
      cl3 = cl3 - ACC_W'(wr2);
    end
    if (cl3 < 0) begin
      clOut3 = '0;
      clipNow = 1'b1;
    end else if (cl3 > ACC_W'(LSB_MAX)) begin
      clOut3 = '1;
      clipNow = 1'b1;
    end else begin
      clOut3 = cl3[LSB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msbCode <= '0; isbCode <= '0; lsbCode <= '0; redA <= 1'b0; redB <= 1'b0;
    end else if (strb.ld3) begin
      msbCode <= s2Cm; isbCode <= ci3; lsbCode <= clOut3; redA <= s2Sw1; redB <= sw2n;
    end
  end

  // R3 R4
  low_window_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.ld2 && !s1Sw1) |-> (s1Low >= 0 && s1Low <= ACC_W'(ISB_TOP)));

  // R5
  round_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.ld3 && !s2Clip) |-> (s2Res >= -ACC_W'(HALF) && s2Res < ACC_W'(HALF)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.ld3 |=> ($stable(msbCode) && $stable(isbCode) && $stable(lsbCode)
                   && $stable(redA) && $stable(redB)));
endmodule

// File: rtl/dac_code_remapper.sv
module dac_code_remapper
  import remap_pkg::*;
#(
  parameter int MSB_W = 5,
  parameter int ISB_W = 4,
  parameter int LSB_W = 5,
  parameter int ERR_W = 8,
  parameter int CFG_W = 10,
  localparam int ADDR_W = (MSB_W > ISB_W) ? MSB_W : ISB_W,
  localparam int CODE_W = MSB_W + ISB_W + LSB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  output logic              outValid,
  output logic [MSB_W-1:0]  msbCode,
  output logic [ISB_W-1:0]  isbCode,
  output logic [LSB_W-1:0]  lsbCode,
  output logic              redA,
  output logic              redB,
  output logic              errFlag
);
  stageStrobe_t strb;
  logic         clipNow;

  remap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .clipNow(clipNow),
    .strb(strb), .outValid(outValid), .errFlag(errFlag)
  );

  remap_datapath #(
    .MSB_W(MSB_W), .ISB_W(ISB_W), .LSB_W(LSB_W),
    .ERR_W(ERR_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .codeIn(codeIn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .msbCode(msbCode), .isbCode(isbCode), .lsbCode(lsbCode),
    .redA(redA), .redB(redB), .clipNow(clipNow)
  );
endmodule

// File: tb/dac_code_remapper_tb.sv
`timescale 1ns/1ps
module dac_code_remapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [13:0] codeIn = '0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [4:0]  cfgAddr = '0;
  logic [9:0]  cfgData = '0;
  logic        outValid, redA, redB, errFlag;
  logic [4:0]  msbCode, lsbCode;
  logic [3:0]  isbCode;

  dac_code_remapper u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .codeIn(codeIn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .msbCode(msbCode), .isbCode(isbCode), .lsbCode(lsbCode),
    .redA(redA), .redB(redB), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit clipAcc = 1'b0;
  int bEm [32];
  int bEi [16];
  int bWr1, bWr2, bThr;
  logic [16:0] expQ [$];
  int tQ [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [16:0] model(input int code);
    int cm, ci, cl, low, r, cln;
    bit clip, r1, r2;
    cm = code >> 9; ci = (code >> 5) & 15; cl = code & 31;
    clip = 0; r1 = 0; r2 = 0;
    low = ci * 32 + cl - bEm[cm];
    if (low < 0) begin
      if (cm == 0) begin low = 0; clip = 1; end
      else begin cm--; low += 512; end
    end
    if (low > 480) begin r1 = 1; low -= bWr1; end
    r = (low + 16) >>> 5;
    if (r < 0) begin r = 0; clip = 1; end
    else if (r > 15) begin r = 15; clip = 1; end
    cln = low - r * 32 - bEi[r];
    if (cln < 0) begin
      if (r == 0) clip = 1;
      else begin r--; cln += 32; end
    end
    if (cln > bThr) begin r2 = 1; cln -= bWr2; end
    if (cln < 0) begin cln = 0; clip = 1; end
    else if (cln > 31) begin cln = 31; clip = 1; end
    return {clip, 5'(cm), 4'(r), 5'(cln), r1, r2};
  endfunction

  task automatic resetTables();
    for (int i = 0; i < 32; i++) bEm[i] = 0;
    for (int i = 0; i < 16; i++) bEi[i] = 0;
    bWr1 = 0; bWr2 = 0; bThr = 31;
    clipAcc = 1'b0;
  endtask

  // R9 write encoding
  task automatic cfgWrite(input int sel, input int addr, input int val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'(sel); cfgAddr = 5'(addr); cfgData = 10'(val);
    @(negedge clk);
    cfgWe = 1'b0;
    if (sel == 0) bEm[addr] = val;
    else if (sel == 1) bEi[addr] = val;
    else if (addr == 0) bWr1 = val;
    else if (addr == 1) bWr2 = val;
    else bThr = val;
  endtask

  task automatic sendCode(input int c);
    @(negedge clk);
    inValid = 1'b1; codeIn = 14'(c);
    expQ.push_back(model(c));
    tQ.push_back(cyc);
  endtask

  task automatic drain();
    @(negedge clk);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // output monitor: R2 timing, R3..R7 values
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected outValid", 1, 0);
      end else begin
        logic [16:0] e;
        int t;
        logic [15:0] got;
        e = expQ.pop_front();
        t = tQ.pop_front();
        chk(cyc - t == 3, "R2 latency", cyc - t, 3);
        got = {msbCode, isbCode, lsbCode, redA, redB};
        chk(got == e[15:0], "R3/R4/R5/R6/R7 codes {msb,isb,lsb,rA,rB}", int'(got), int'(e[15:0]));
        clipAcc = clipAcc | e[16];
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    resetTables();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    chk(errFlag == 1'b0, "R1 errFlag in reset", int'(errFlag), 0);
    chk({msbCode, isbCode, lsbCode, redA, redB} == '0, "R1 codes in reset",
        int'({msbCode, isbCode, lsbCode, redA, redB}), 0);
    rst = 1'b0;
    // R1 default tables: a mid-range code passes through unchanged
    sendCode(14'h2345);
    sendCode(14'h0000);
    drain();

    // Config A: zero errors, first weight 32; exhaustive sweep, back to back
    cfgWrite(2, 0, 32);
    for (int c = 0; c < 16384; c++) sendCode(c);
    drain();
    chk(errFlag == clipAcc, "R8 sticky after config A", int'(errFlag), int'(clipAcc));

    // R10: outputs hold while idle
    held = {msbCode, isbCode, lsbCode, redA, redB};
    repeat (5) @(negedge clk);
    chk(outValid == 1'b0, "R10 outValid idle", int'(outValid), 0);
    chk({msbCode, isbCode, lsbCode, redA, redB} == held, "R10 hold",
        int'({msbCode, isbCode, lsbCode, redA, redB}), int'(held));

    // Config B: spread signed errors, weights and a lowered threshold
    for (int i = 0; i < 32; i++) cfgWrite(0, i, ((i * 37 + 11) % 61) - 30);
    for (int i = 0; i < 16; i++) cfgWrite(1, i, ((i * 13 + 5) % 25) - 12);
    cfgWrite(2, 0, 250);
    cfgWrite(2, 1, 20);
    cfgWrite(2, 2, 28);
    for (int c = 0; c < 16384; c++) sendCode(c);
    drain();
    chk(errFlag == clipAcc, "R8 sticky after config B", int'(errFlag), int'(clipAcc));

    // R8: forced underflow at upper code 0 clamps and raises the flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    resetTables();
    chk(errFlag == 1'b0, "R8 flag cleared by reset", int'(errFlag), 0);
    cfgWrite(0, 0, 100);
    sendCode(0);
    drain();
    chk(errFlag == 1'b1, "R8 flag after clamp", int'(errFlag), 1);
    chk(clipAcc == 1'b1, "R8 model clamp expected", int'(clipAcc), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule